// File: doc/BRIEF.md
# Per-line load-linked reservation monitor

This block tracks load-linked / store-conditional reservations for a small set-associative data cache. Beside every tag entry sits a lock field naming the hardware context that holds a reservation on that line. Requests (load-linked, store-conditional, ordinary store) come in with an address and a context ID. The block looks the address up in its own tag array, updates the lock of the line that hit, and one cycle later reports whether the request succeeded. A store-conditional succeeds only if the requester still owns the line's lock. An ordinary store or an invalidate clears a lock only when the lock belongs to the context named with it.

The invalidate port is raised by the coherence controller when permission for a line is lost. A line-update port installs a tag into a chosen way (refill) or drops it (evict). Both actions return that way's lock to the unlocked state. Data storage, the coherence protocol and the victim choice all live outside.

A small controller sequences the block with two states. `S_SWEEP` is entered on reset. It clears one set per cycle, marking every way invalid and unlocked, and holds `req_ready` low. The transition `sweep_done` moves to `S_SERVE` after the last set. In `S_SERVE`, `req_ready` is high and one request is accepted per cycle. The only way out of `S_SERVE` is reset, which returns to `S_SWEEP`.

Top module: `resv_monitor`

## Requirements
- R1: After reset is released, `req_ready` stays low for exactly SETS cycles, counting the cycle in which reset is released, and then stays high. `rsp_valid` is low throughout.
- R2: `rsp_valid` is high in exactly the cycle after a request is accepted (`req_valid && req_ready`), and low otherwise.
- R3: A load-linked (`req_kind` 2'b00) that hits always returns `rsp_ok`=1 and makes the requester the owner of the line's lock. A later store-conditional by that context then succeeds.
- R4: A store-conditional (`req_kind` 2'b01) that hits returns `rsp_ok`=1 only if the line's lock holds the requester's context ID. It returns `rsp_ok`=0 if the line is unlocked or owned by another context.
- R5: Every store-conditional that hits leaves the line unlocked, whether it succeeds or fails.
- R6: An ordinary store (`req_kind` 2'b10 or 2'b11) returns `rsp_ok`=1. It unlocks the line only if the lock holds the requester's ID, and leaves another context's lock untouched.
- R7: An invalidate (`inv_valid`) whose address hits unlocks that line only if the lock holds `inv_ctx`.
- R8: A request whose address misses returns `rsp_ok`=1 and changes no lock.
- R9: A refill (`upd_valid`, `upd_evict`=0) or an evict (`upd_evict`=1) of a way unlocks that way. After an evict, the line misses.
- R10: When an invalidate and a request hit the same line in one cycle, the invalidate takes effect first and the request sees its result.
- R11: A load-linked replaces a lock held by another context with the requester's ID.
- R12: The address is split into tag (upper bits), set index `addr[OFF_W +: SET_W]` and offset (low OFF_W bits). Context ID all-ones is reserved as the unlocked marker and is never used by a requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_kind | input | 2 | 00 load-linked, 01 store-conditional, 1x ordinary store |
| req_addr | input | ADDR_W | Request byte address |
| req_ctx | input | CTX_W | Requesting context ID |
| inv_valid | input | 1 | Coherence permission lost for a line |
| inv_addr | input | ADDR_W | Address of the line losing permission |
| inv_ctx | input | CTX_W | Context whose reservation the invalidate clears |
| upd_valid | input | 1 | Refill or evict a way |
| upd_evict | input | 1 | 1 evicts the way, 0 refills it with the tag of `upd_addr` |
| upd_addr | input | ADDR_W | Address whose set and tag the update uses |
| upd_way | input | WAY_W | Way being refilled or evicted |
| rsp_valid | output | 1 | Result of the request accepted last cycle |
| rsp_ok | output | 1 | 1 success, 0 store-conditional failed |

## Verification
Directed sequences separate the ownership rules. Each places a load-linked, then a store, invalidate or second load-linked by the same or a different context, then a store-conditional. This tells the owner-only clear apart from an unconditional clear, and an always-succeeding store-conditional apart from a correct one. Addresses that share a set but miss check that a miss never disturbs a neighbour's lock. Refills and evicts separate a lock that follows the way from one that follows the address. An invalidate and a request on the same line in one cycle decide which of the two is applied first. A long random mix of all request kinds, invalidates and updates over two sets and four contexts is compared against a sequential bench model.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        K_LL  = 2'b00,
        K_SC  = 2'b01,
        K_ST  = 2'b10,
        K_STX = 2'b11
    } req_kind_e;

    typedef enum logic {
        S_SWEEP = 1'b0,
        S_SERVE = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
    import resv_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             req_ready,
    output logic             sweep_en,
    output logic [SET_W-1:0] sweep_set
);

    ctl_state_e       state_q;
    logic [SET_W-1:0] cnt_q;
    logic             sweep_done;

    assign sweep_done = (cnt_q == SET_W'(SETS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_SWEEP;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                S_SWEEP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (sweep_done) state_q <= S_SERVE;
                end
                S_SERVE: state_q <= S_SERVE;
                default: state_q <= S_SWEEP;
            endcase
        end
    end

    always_comb begin
        req_ready = 1'b0;
        sweep_en  = 1'b0;
        sweep_set = cnt_q;
        unique case (state_q)
            S_SWEEP: sweep_en  = 1'b1;
            S_SERVE: req_ready = 1'b1;
            default: sweep_en  = 1'b0;
        endcase
    end

    // R1: once serving, the block never falls back to the sweep without reset
    p_serve_sticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);

endmodule

// File: rtl/resv_lookup.sv
module resv_lookup #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int SET_W  = 4,
    parameter int TAG_W  = 8,
    parameter int WAY_W  = 2
) (
    input  logic [ADDR_W-1:0]                        addr,
    input  logic [SETS-1:0][WAYS-1:0]                valid_tbl,
    input  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]     tag_tbl,
    output logic                                     hit,
    output logic [SET_W-1:0]                         set_idx,
    output logic [WAY_W-1:0]                         way_idx
);

    logic [TAG_W-1:0] tag;
    logic [WAYS-1:0]  match;
    logic             unused_off;

    assign set_idx    = addr[OFF_W +: SET_W];
    assign tag        = addr[ADDR_W-1 -: TAG_W];
    assign unused_off = ^addr[OFF_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = valid_tbl[set_idx][w] && (tag_tbl[set_idx][w] == tag);
    end

    always_comb begin
        way_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) way_idx = WAY_W'(w);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/resv_line_store.sv
module resv_line_store
    import resv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int CTX_W  = 3,
    parameter int SET_W  = 4,
    parameter int TAG_W  = 8,
    parameter int WAY_W  = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 sweep_en,
    input  logic [SET_W-1:0]                     sweep_set,
    input  logic                                 upd_valid,
    input  logic                                 upd_evict,
    input  logic [ADDR_W-1:0]                    upd_addr,
    input  logic [WAY_W-1:0]                     upd_way,
    input  logic                                 inv_valid,
    input  logic [CTX_W-1:0]                     inv_ctx,
    input  logic                                 inv_hit,
    input  logic [SET_W-1:0]                     inv_set,
    input  logic [WAY_W-1:0]                     inv_way,
    input  logic                                 acc,
    input  logic [1:0]                           req_kind,
    input  logic [CTX_W-1:0]                     req_ctx,
    input  logic                                 req_hit,
    input  logic [SET_W-1:0]                     req_set,
    input  logic [WAY_W-1:0]                     req_way,
    output logic [SETS-1:0][WAYS-1:0]            valid_q,
    output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q,
    output logic                                 rsp_valid,
    output logic                                 rsp_ok
);

    localparam logic [CTX_W-1:0] UNLOCK = '1;

    logic [CTX_W-1:0] lock_q [SETS][WAYS];

    logic [SET_W-1:0] upd_set;
    logic [TAG_W-1:0] upd_tag;
    logic             unused_upd_off;
    logic             inv_kills;
    logic             same_line;
    logic [CTX_W-1:0] lock_seen;
    logic             owner;
    logic             req_wr;
    logic [CTX_W-1:0] req_val;
    logic             ok_d;
    req_kind_e        kind;

    assign upd_set        = upd_addr[OFF_W +: SET_W];
    assign upd_tag        = upd_addr[ADDR_W-1 -: TAG_W];
    assign unused_upd_off = ^upd_addr[OFF_W-1:0];
    assign kind           = req_kind_e'(req_kind);

    // invalidate is resolved ahead of the request on the same line
    assign inv_kills = inv_valid && inv_hit && (lock_q[inv_set][inv_way] == inv_ctx);
    assign same_line = req_hit && inv_hit && (inv_set == req_set) && (inv_way == req_way);
    assign lock_seen = (same_line && inv_kills) ? UNLOCK : lock_q[req_set][req_way];
    assign owner     = (lock_seen == req_ctx);

    always_comb begin
        req_wr  = 1'b0;
        req_val = UNLOCK;
        ok_d    = 1'b1;
        if (acc && req_hit) begin
            unique case (kind)
                K_LL: begin
                    req_wr  = 1'b1;
                    req_val = req_ctx;
                end
                K_SC: begin
                    req_wr = 1'b1;
                    ok_d   = owner;
                end
                K_ST, K_STX: req_wr = owner;
                default: req_wr = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (sweep_en && (sweep_set == SET_W'(s))) begin
                    valid_q[s][w] <= 1'b0;
                    lock_q[s][w]  <= UNLOCK;
                end else if (upd_valid && (upd_set == SET_W'(s)) && (upd_way == WAY_W'(w))) begin
                    valid_q[s][w] <= !upd_evict;
                    if (!upd_evict) tag_q[s][w] <= upd_tag;
                    lock_q[s][w] <= UNLOCK;
                end else if (req_wr && (req_set == SET_W'(s)) && (req_way == WAY_W'(w))) begin
                    lock_q[s][w] <= req_val;
                end else if (inv_kills && (inv_set == SET_W'(s)) && (inv_way == WAY_W'(w))) begin
                    lock_q[s][w] <= UNLOCK;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= acc;
            rsp_ok    <= acc ? ok_d : 1'b0;
        end
    end

    // checker copies of the request line, taken every cycle
    logic [SET_W-1:0] chk_set_q;
    logic [WAY_W-1:0] chk_way_q;
    logic [CTX_W-1:0] chk_lock_q;
    logic [CTX_W-1:0] chk_ctx_q;
    logic             upd_same;

    assign upd_same = upd_valid && (upd_set == req_set) && (upd_way == req_way);

    always_ff @(posedge clk) begin
        chk_set_q  <= req_set;
        chk_way_q  <= req_way;
        chk_lock_q <= lock_q[req_set][req_way];
        chk_ctx_q  <= req_ctx;
    end

    // R8: a miss always reports success
    p_miss_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_hit) |=> rsp_ok);

    // R5: a store-conditional that hit leaves its line unlocked
    p_sc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_hit && (kind == K_SC) && !upd_same)
        |=> (lock_q[chk_set_q][chk_way_q] == UNLOCK));

    // R3: a load-linked that hit hands the lock to the requester
    p_ll_owns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_hit && (kind == K_LL) && !upd_same)
        |=> (lock_q[chk_set_q][chk_way_q] == chk_ctx_q));

    // R6: a store by a non-owner leaves the lock as it was
    p_other_st_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_hit && req_kind[1] && (lock_q[req_set][req_way] != req_ctx)
         && !upd_same && !(same_line && inv_kills))
        |=> (lock_q[chk_set_q][chk_way_q] == chk_lock_q));

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int CTX_W  = 3,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - SET_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic [CTX_W-1:0]  inv_ctx,
    input  logic              upd_valid,
    input  logic              upd_evict,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [WAY_W-1:0]  upd_way,
    output logic              rsp_valid,
    output logic              rsp_ok
);

    logic                                 sweep_en;
    logic [SET_W-1:0]                     sweep_set;
    logic [SETS-1:0][WAYS-1:0]            valid_tbl;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_tbl;
    logic                                 req_hit, inv_hit;
    logic [SET_W-1:0]                     req_set, inv_set;
    logic [WAY_W-1:0]                     req_way, inv_way;
    logic                                 acc;
    logic                                 inv_live;

    assign acc      = req_valid && req_ready;
    assign inv_live = inv_valid && !sweep_en;

    resv_ctrl #(.SETS(SETS), .SET_W(SET_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_ready (req_ready),
        .sweep_en  (sweep_en),
        .sweep_set (sweep_set)
    );

    resv_lookup #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS),
        .SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) req_look_i (
        .addr      (req_addr),
        .valid_tbl (valid_tbl),
        .tag_tbl   (tag_tbl),
        .hit       (req_hit),
        .set_idx   (req_set),
        .way_idx   (req_way)
    );

    resv_lookup #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS),
        .SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) inv_look_i (
        .addr      (inv_addr),
        .valid_tbl (valid_tbl),
        .tag_tbl   (tag_tbl),
        .hit       (inv_hit),
        .set_idx   (inv_set),
        .way_idx   (inv_way)
    );

    resv_line_store #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS), .CTX_W(CTX_W),
        .SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep_en  (sweep_en),
        .sweep_set (sweep_set),
        .upd_valid (upd_valid && !sweep_en),
        .upd_evict (upd_evict),
        .upd_addr  (upd_addr),
        .upd_way   (upd_way),
        .inv_valid (inv_live),
        .inv_ctx   (inv_ctx),
        .inv_hit   (inv_hit),
        .inv_set   (inv_set),
        .inv_way   (inv_way),
        .acc       (acc),
        .req_kind  (req_kind),
        .req_ctx   (req_ctx),
        .req_hit   (req_hit),
        .req_set   (req_set),
        .req_way   (req_way),
        .valid_q   (valid_tbl),
        .tag_q     (tag_tbl),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok)
    );

    // R2: a response follows every accepted request, and only those
    p_rsp_follows_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

endmodule

// File: tb/resv_monitor_tb_top.sv
`timescale 1ns/100ps
module resv_monitor_tb_top;

    localparam int SETS = 16;
    localparam int WAYS = 4;
    localparam int UNL  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_ctx = '0;
    logic        inv_valid = 1'b0;
    logic [15:0] inv_addr = '0;
    logic [2:0]  inv_ctx = '0;
    logic        upd_valid = 1'b0;
    logic        upd_evict = 1'b0;
    logic [15:0] upd_addr = '0;
    logic [1:0]  upd_way = '0;
    logic        rsp_valid;
    logic        rsp_ok;

    always #2.5 clk = ~clk;

    resv_monitor dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_ctx(req_ctx),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ctx(inv_ctx),
        .upd_valid(upd_valid), .upd_evict(upd_evict), .upd_addr(upd_addr),
        .upd_way(upd_way), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
    );

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    bit m_valid [SETS][WAYS];
    int m_tag   [SETS][WAYS];
    int m_lock  [SETS][WAYS];

    function automatic logic [15:0] mk(int tag, int set);
        return 16'((tag << 8) | (set << 4) | 3);
    endfunction

    function automatic bit m_find(logic [15:0] a, output int s, output int w);
        s = int'(a[7:4]);
        w = 0;
        for (int i = 0; i < WAYS; i++) begin
            if (m_valid[s][i] && m_tag[s][i] == int'(a[15:8])) begin
                w = i;
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic check(string rq, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    // inputs are applied in order: invalidate, then request, then update
    task automatic predict(output bit ev, output bit eok);
        int s, w;
        ev = 1'b0; eok = 1'b0;
        if (inv_valid && m_find(inv_addr, s, w))
            if (m_lock[s][w] == int'(inv_ctx)) m_lock[s][w] = UNL;
        if (req_valid) begin
            ev = 1'b1; eok = 1'b1;
            if (m_find(req_addr, s, w)) begin
                case (req_kind)
                    2'b00: m_lock[s][w] = int'(req_ctx);
                    2'b01: begin
                        eok = (m_lock[s][w] == int'(req_ctx));
                        m_lock[s][w] = UNL;
                    end
                    default: if (m_lock[s][w] == int'(req_ctx)) m_lock[s][w] = UNL;
                endcase
            end
        end
        if (upd_valid) begin
            s = int'(upd_addr[7:4]);
            w = int'(upd_way);
            m_valid[s][w] = !upd_evict;
            if (!upd_evict) m_tag[s][w] = int'(upd_addr[15:8]);
            m_lock[s][w] = UNL;
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; inv_valid = 1'b0; upd_valid = 1'b0;
    endtask

    task automatic step(string rq);
        bit ev, eok;
        predict(ev, eok);
        @(posedge clk);
        @(negedge clk);
        check({rq, " rsp_valid"}, int'(rsp_valid), int'(ev));
        if (ev) check({rq, " rsp_ok"}, int'(rsp_ok), int'(eok));
        idle();
    endtask

    task automatic rq(int kind, int tag, int set, int ctx);
        req_valid = 1'b1; req_kind = 2'(kind); req_addr = mk(tag, set); req_ctx = 3'(ctx);
    endtask

    task automatic iv(int tag, int set, int ctx);
        inv_valid = 1'b1; inv_addr = mk(tag, set); inv_ctx = 3'(ctx);
    endtask

    task automatic up(bit ev_, int tag, int set, int way);
        upd_valid = 1'b1; upd_evict = ev_; upd_addr = mk(tag, set); upd_way = 2'(way);
    endtask

    function automatic bit tag_in_set(int set, int tag, int skip_way);
        for (int i = 0; i < WAYS; i++)
            if (i != skip_way && m_valid[set][i] && m_tag[set][i] == tag) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int lows;
        int seed;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_tag[s][w] = 0; m_lock[s][w] = UNL;
            end
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        lows = 0;
        while (!req_ready && lows < 100) begin
            if (rsp_valid) check("R1 rsp_valid in sweep", 1, 0);
            lows++;
            @(negedge clk);
        end
        check("R1 sweep length", lows, SETS);
        @(negedge clk);
        check("R1 ready stays high", int'(req_ready), 1);

        // R9 population
        for (int w = 0; w < WAYS; w++) begin up(0, 10 + w, 1, w); step("R9 fill"); end
        up(0, 20, 2, 0); step("R9 fill");
        check("R12 miss before fill is not a hit", int'(m_valid[3][0]), 0);

        // R3 R4
        rq(0, 10, 1, 1); step("R3 LL");
        rq(1, 10, 1, 1); step("R3 SC by owner");
        // R5
        rq(1, 10, 1, 1); step("R5 SC after SC");
        // R4
        rq(1, 11, 1, 2); step("R4 SC unlocked");
        rq(0, 11, 1, 1); step("R4 LL");
        rq(1, 11, 1, 2); step("R4 SC other ctx");
        rq(1, 11, 1, 1); step("R5 SC after failed SC");
        // R11
        rq(0, 12, 1, 1); step("R11 LL a");
        rq(0, 12, 1, 2); step("R11 LL b");
        rq(1, 12, 1, 1); step("R11 SC old owner");
        rq(0, 12, 1, 1); step("R11 LL a");
        rq(0, 12, 1, 2); step("R11 LL b");
        rq(1, 12, 1, 2); step("R11 SC new owner");
        // R6
        rq(0, 13, 1, 1); step("R6 LL");
        rq(2, 13, 1, 2); step("R6 store other");
        rq(1, 13, 1, 1); step("R6 SC survives store");
        rq(0, 13, 1, 1); step("R6 LL");
        rq(3, 13, 1, 1); step("R6 store owner");
        rq(1, 13, 1, 1); step("R6 SC after own store");
        // R7
        rq(0, 10, 1, 1); step("R7 LL");
        iv(10, 1, 2); step("R7 inv other");
        rq(1, 10, 1, 1); step("R7 SC survives inv");
        rq(0, 10, 1, 1); step("R7 LL");
        iv(10, 1, 1); step("R7 inv owner");
        rq(1, 10, 1, 1); step("R7 SC after inv");
        // R8
        rq(1, 99, 1, 1); step("R8 SC miss");
        rq(0, 10, 1, 1); step("R8 LL");
        rq(0, 99, 1, 2); step("R8 LL miss same set");
        rq(2, 98, 1, 1); step("R8 store miss same set");
        rq(1, 10, 1, 1); step("R8 SC unaffected by misses");
        // R9
        rq(0, 10, 1, 1); step("R9 LL");
        up(0, 10, 1, 0); step("R9 refill");
        rq(1, 10, 1, 1); step("R9 SC after refill");
        up(1, 10, 1, 0); step("R9 evict");
        rq(1, 10, 1, 1); step("R9 SC after evict misses");
        up(0, 10, 1, 0); step("R9 refill back");
        // R10
        rq(0, 10, 1, 1); step("R10 LL");
        rq(1, 10, 1, 1); iv(10, 1, 1); step("R10 inv+SC same line");
        rq(0, 10, 1, 3); step("R10 LL");
        rq(0, 10, 1, 2); iv(10, 1, 3); step("R10 inv+LL same line");
        rq(1, 10, 1, 2); step("R10 SC by new owner");

        // random phase
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int n = 0; n < 4000; n++) begin
            int tsel, set, way, tg;
            int tags [6] = '{10, 11, 12, 13, 20, 99};
            if ($urandom_range(99) < 70) begin
                tsel = $urandom_range(5);
                set = ($urandom_range(1) == 0) ? 1 : 2;
                rq($urandom_range(3), tags[tsel], set, $urandom_range(3));
            end
            if ($urandom_range(99) < 20) begin
                tsel = $urandom_range(5);
                set = ($urandom_range(1) == 0) ? 1 : 2;
                iv(tags[tsel], set, $urandom_range(3));
            end
            if ($urandom_range(99) < 5) begin
                set = ($urandom_range(1) == 0) ? 1 : 2;
                way = $urandom_range(3);
                tg = tags[$urandom_range(5)];
                if (tag_in_set(set, tg, way)) up(1, tg, set, way);
                else up($urandom_range(3) == 0, tg, set, way);
            end
            step("R4 random mix");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule